// File: doc/BRIEF.md
# Framed 16-bit Serial Register-Write Receiver

This block is the slave end of a write-only serial link. A host lowers an active-low frame line, then clocks in a 16-bit command word one bit per falling serial-clock edge, most significant bit first, and raises the frame line again. The word holds three fields. The top nibble is a control code. The next nibble selects one of sixteen 8-bit registers. The low byte is the value to store in that register.

The three serial inputs are brought into the system clock domain through two-flop synchronisers, and edges are detected there. The system clock must run at least four times faster than the serial clock. A host that can only shift eight bits at a time keeps the frame low, lets the serial clock idle high, and then sends a second byte. The receiver treats this the same as one continuous 16-bit burst. A write is committed only when the frame closes after exactly sixteen bits. Frames with fewer or more bits are dropped. When a write is committed, the block updates the addressed register and the stored control nibble, and pulses a strobe for one system cycle.

Top module: `frame_word_rx`

## Requirements
- R1: While and after reset, all sixteen registers read zero, the stored control nibble reads zero and the write strobe is low.
- R2: A frame of exactly 16 bits, sampled on serial-clock falling edges with the first bit as bit 15, writes bits 7:0 into the register whose index is bits 11:8. Register n occupies reg_q[8n+7:8n].
- R3: A word sent as two 8-bit bursts, with the serial clock idling high between them and the frame held low throughout, is committed exactly like a single 16-bit burst.
- R4: On each committed word, ctrl_q takes bits 15:12 of that word and holds them until the next committed word.
- R5: A frame that closes after fewer than 16 bits causes no register change, no control change and no strobe.
- R6: A frame that closes after more than 16 bits causes no register change, no control change and no strobe.
- R7: Serial-clock falling edges that occur while the frame line is high shift in nothing and do not disturb the next frame.
- R8: Each committed word produces exactly one write strobe, and that strobe is one system cycle wide.
- R9: Each falling edge of the frame line starts a new word from bit zero, whatever happened in the frame before it.
- R10: A committed write changes only the addressed register. The other fifteen keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fs_n | input | 1 | Active-low frame line, asynchronous |
| sclk | input | 1 | Serial clock, idles high, asynchronous |
| sdat | input | 1 | Serial data, sampled on sclk falling edge |
| reg_q | output | 128 | Sixteen 8-bit registers, register n at bits 8n+7:8n |
| ctrl_q | output | 4 | Control nibble of the last committed word |
| wr_strobe | output | 1 | One-cycle pulse when a word is committed |

## Verification
The hardest case to reach from the ports is a host that splits one word into two bytes. The frame has to stay low across a long idle gap with the serial clock held high, and the bit count must carry over that gap. The stimulus stretches the gap to many serial periods. It also sends a short frame, and separately stray serial-clock edges with the frame high, each immediately followed by a good word. A wrong count carried from one frame into the next then shows up as a wrong register value or a missing strobe.

// File: rtl/fwrx_pkg.sv
package fwrx_pkg;

  // Receive state of the deframer
  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,  // frame line high, edges ignored
    FR_RECV = 2'd1,  // collecting bits
    FR_OVER = 2'd2   // too many bits, frame will be discarded
  } fr_state_e;

endpackage

// File: rtl/fwrx_sync.sv
module fwrx_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= RST_VAL;
        else     stage_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= RST_VAL;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/fwrx_deframer.sv
module fwrx_deframer
  import fwrx_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              fs_n_s,
  input  logic              sdat_s,
  output logic              word_vld,
  output logic [WORD_W-1:0] word_q
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

  logic              sclk_d;
  logic              fs_d;
  logic              sclk_fall;
  logic              fs_fall;
  logic              fs_rise;
  fr_state_e         state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b1;
      fs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      fs_d   <= fs_n_s;
    end
  end

  assign sclk_fall = sclk_d & ~sclk_s;
  assign fs_fall   = fs_d & ~fs_n_s;
  assign fs_rise   = ~fs_d & fs_n_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= FR_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      word_vld <= 1'b0;
      word_q   <= '0;
    end else begin
      word_vld <= 1'b0;
      if (fs_fall) begin
        state   <= FR_RECV;
        bit_cnt <= '0;
      end else if (fs_rise) begin
        if (state == FR_RECV && bit_cnt == FULL_CNT) begin
          word_vld <= 1'b1;
          word_q   <= shreg;
        end
        state   <= FR_IDLE;
        bit_cnt <= '0;
      end else if (sclk_fall && !fs_n_s && state == FR_RECV) begin
        if (bit_cnt == FULL_CNT) begin
          state <= FR_OVER;
        end else begin
          shreg   <= {shreg[WORD_W-2:0], sdat_s};
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/fwrx_regfile.sv
module fwrx_regfile #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int CTRL_W = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [CTRL_W-1:0]          wctrl,
  input  logic [ADDR_W-1:0]          waddr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [(1<<ADDR_W)*DATA_W-1:0] reg_q,
  output logic [CTRL_W-1:0]          ctrl_q,
  output logic                       wr_strobe
);

  localparam int NUM_REGS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      wr_strobe <= 1'b0;
    end else begin
      wr_strobe <= we;
      if (we) ctrl_q <= wctrl;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    assign reg_q[g*DATA_W +: DATA_W] = mem[g];
  end

endmodule

// File: rtl/frame_word_rx.sv
module frame_word_rx #(
  parameter int CTRL_W      = 4,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          fs_n,
  input  logic                          sclk,
  input  logic                          sdat,
  output logic [(1<<ADDR_W)*DATA_W-1:0] reg_q,
  output logic [CTRL_W-1:0]             ctrl_q,
  output logic                          wr_strobe
);

  localparam int WORD_W = CTRL_W + ADDR_W + DATA_W;

  logic [2:0]        sync_q;
  logic              word_vld;
  logic [WORD_W-1:0] word;

  fwrx_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b011)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sdat, fs_n, sclk}),
    .q   (sync_q)
  );

  fwrx_deframer #(
    .WORD_W (WORD_W)
  ) u_deframer (
    .clk      (clk),
    .rst      (rst),
    .sclk_s   (sync_q[0]),
    .fs_n_s   (sync_q[1]),
    .sdat_s   (sync_q[2]),
    .word_vld (word_vld),
    .word_q   (word)
  );

  fwrx_regfile #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CTRL_W (CTRL_W)
  ) u_regfile (
    .clk       (clk),
    .rst       (rst),
    .we        (word_vld),
    .wctrl     (word[WORD_W-1 -: CTRL_W]),
    .waddr     (word[DATA_W +: ADDR_W]),
    .wdata     (word[DATA_W-1:0]),
    .reg_q     (reg_q),
    .ctrl_q    (ctrl_q),
    .wr_strobe (wr_strobe)
  );

endmodule

// File: rtl/fwrx_chk.sv
module fwrx_chk #(
  parameter int CTRL_W = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic                          clk,
  input logic                          rst,
  input logic [(1<<ADDR_W)*DATA_W-1:0] reg_q,
  input logic [CTRL_W-1:0]             ctrl_q,
  input logic                          wr_strobe
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (reg_q == '0 && ctrl_q == '0 && !wr_strobe));

  // R8
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    wr_strobe |=> !wr_strobe);

  // R10
  regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_strobe |-> $stable(reg_q));

  // R4
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_strobe |-> $stable(ctrl_q));

endmodule

bind frame_word_rx fwrx_chk #(
  .CTRL_W (CTRL_W),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_q     (reg_q),
  .ctrl_q    (ctrl_q),
  .wr_strobe (wr_strobe)
);

// File: tb/sim_frame_word_rx.sv
module sim_frame_word_rx;

  localparam int CLK_P  = 10;
  localparam int SHALF  = 4;   // system cycles per serial half period

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         fs_n = 1'b1;
  logic         sclk = 1'b1;
  logic         sdat = 1'b0;
  logic [127:0] reg_q;
  logic [3:0]   ctrl_q;
  logic         wr_strobe;

  int total = 0;
  int bad = 0;
  int stb_cnt = 0;
  int wide_cnt = 0;
  logic prev_stb = 1'b0;
  bit done = 1'b0;

  logic [7:0] exp_mem [16];
  logic [3:0] exp_ctrl = 4'h0;

  always #(CLK_P/2) clk = ~clk;

  frame_word_rx u0 (
    .clk       (clk),
    .rst       (rst),
    .fs_n      (fs_n),
    .sclk      (sclk),
    .sdat      (sdat),
    .reg_q     (reg_q),
    .ctrl_q    (ctrl_q),
    .wr_strobe (wr_strobe)
  );

  always @(posedge clk) begin
    if (rst) begin
      prev_stb <= 1'b0;
    end else begin
      if (wr_strobe) stb_cnt <= stb_cnt + 1;
      if (wr_strobe && prev_stb) wide_cnt <= wide_cnt + 1;
      prev_stb <= wr_strobe;
    end
  end

  function automatic logic [127:0] exp_vec();
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[i*8 +: 8] = exp_mem[i];
    return v;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk(req, reg_q, exp_vec());
    chk(req, {124'd0, ctrl_q}, {124'd0, exp_ctrl});
  endtask

  task automatic shift_bits(input int n, input logic [31:0] val);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = val[i];
      cyc(SHALF);
      sclk = 1'b0;
      cyc(SHALF);
      sclk = 1'b1;
    end
  endtask

  task automatic frame_bits(input int n, input logic [31:0] val);
    fs_n = 1'b0;
    cyc(SHALF);
    shift_bits(n, val);
    cyc(SHALF);
    fs_n = 1'b1;
    cyc(12);
  endtask

  task automatic good_word(input logic [15:0] w);
    frame_bits(16, {16'd0, w});
    exp_mem[w[11:8]] = w[7:0];
    exp_ctrl = w[15:12];
  endtask

  task automatic t_reset();
    chk("R1 regs", reg_q, '0);
    chk("R1 ctrl", {124'd0, ctrl_q}, '0);
    chk("R1 strobe", {127'd0, wr_strobe}, '0);
  endtask

  task automatic t_single();
    int s0 = stb_cnt;
    good_word(16'h5A3C);
    chk_state("R2 single burst");
    chk("R8 one strobe", 128'(stb_cnt - s0), 128'd1);
    chk("R4 ctrl", {124'd0, ctrl_q}, 128'h5);
  endtask

  task automatic t_split();
    int s0 = stb_cnt;
    fs_n = 1'b0;
    cyc(SHALF);
    shift_bits(8, 32'h93);
    cyc(40);
    shift_bits(8, 32'hF1);
    cyc(SHALF);
    fs_n = 1'b1;
    cyc(12);
    exp_mem[3] = 8'hF1;
    exp_ctrl = 4'h9;
    chk_state("R3 split bursts");
    chk("R3 one strobe", 128'(stb_cnt - s0), 128'd1);
  endtask

  task automatic t_short();
    int s0 = stb_cnt;
    frame_bits(12, 32'h7B5);
    chk_state("R5 short frame");
    chk("R5 no strobe", 128'(stb_cnt - s0), 128'd0);
  endtask

  task automatic t_long();
    int s0 = stb_cnt;
    frame_bits(20, 32'hE4C77);
    chk_state("R6 long frame");
    chk("R6 no strobe", 128'(stb_cnt - s0), 128'd0);
  endtask

  task automatic t_stray();
    sdat = 1'b1;
    for (int i = 0; i < 5; i++) begin
      cyc(SHALF);
      sclk = 1'b0;
      cyc(SHALF);
      sclk = 1'b1;
    end
    cyc(12);
    chk_state("R7 stray edges no effect");
    good_word(16'h2766);
    chk_state("R7 word after stray edges");
  endtask

  task automatic t_fresh();
    int s0 = stb_cnt;
    frame_bits(7, 32'h55);
    good_word(16'hC0A5);
    chk_state("R9 fresh word after abort");
    chk("R9 one strobe", 128'(stb_cnt - s0), 128'd1);
  endtask

  task automatic t_others();
    good_word(16'h1FFE);
    good_word(16'h4001);
    good_word(16'h6A99);
    chk_state("R10 only addressed reg changes");
    chk("R8 strobe width", 128'(wide_cnt), 128'd0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) exp_mem[i] = 8'h00;
    cyc(5);
    t_reset();
    rst = 1'b0;
    cyc(5);
    t_single();
    t_split();
    t_short();
    t_long();
    t_stray();
    t_fresh();
    t_others();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule